// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single DMA channel. Software loads an 8-bit control word together with a source address, a destination address and a transfer count. Each accepted trigger then moves one data item: one read from the source over a ready/valid memory port, then one write of that data to the destination. The data width is 8, 16 or 32 bits. After every transfer each address either stays put or advances by the item size, and the count steps down.

In normal mode the channel stops when the count runs out. At that point it either pulses a done interrupt or, when chaining is allowed, requests the next descriptor instead. The highest-numbered channel never chains.

In repeat mode one side (source or destination, picked by a select bit) is a repeating area. That side always advances, whatever its increment bit says. When the count runs out, that side's address and the count return to their loaded values, an optional repeat interrupt pulses, and the channel stays armed. A reserved width code, or a trigger that arrives during a transfer, sets a sticky error and causes no bus access.

The sequencer walks these states:
- `ST_IDLE`
- `ST_RD_REQ` (read request held until ready)
- `ST_RD_WAIT` (waits for the read data)
- `ST_WR_REQ` (write request held until ready)
- `ST_UPDATE` (addresses, count and events)

It moves through them as follows:
- idle→read request on a valid trigger.
- read request→read wait on ready.
- read wait→write request on response valid.
- write request→update on ready.
- update→idle always.

Top module: `dma_chan_seq`

## Requirements
- R1: The control word bits are: [7:6] width code, [5] repeat-interrupt enable, [4] chain enable, [3] destination increment, [2] source increment, [1] repeat select (1 = source is the repeat area, 0 = destination), [0] mode (1 = repeat). `ctrl_rd` returns the loaded word in bits [7:0] with bits [15:8] zero, and reads zero after reset. After reset `busy`, `err` and `bus_req_valid` are low.
- R2: A trigger to an armed, idle channel whose width code is 2'b11 sets `err` and produces no bus request. No request ever carries width 2'b11.
- R3: A trigger while `busy` is high sets `err` and starts no extra transfer.
- R4: Each accepted trigger gives exactly one read at the current source address, then one write at the current destination address. The write carries the read data, and both carry the width code on `bus_req_size`. A request stays asserted with a stable address until `bus_req_ready`.
- R5: After a transfer, an address whose increment bit is 1 advances by 1, 2 or 4 bytes for width codes 00, 01 and 10. An address whose increment bit is 0 stays fixed.
- R6: In normal mode the transfer that brings the count to zero ends the block: `irq_done` pulses for one cycle and the channel disarms. Later triggers cause no bus access and no error until the next load.
- R7: With chain enable set in normal mode, the block end pulses `chain_req` instead of `irq_done`. A channel whose `CHAN_ID` equals `NUM_CHAN-1` ignores chain enable and pulses `irq_done`.
- R8: In repeat mode the repeat side advances after every transfer regardless of its increment bit. At the block end its address and the count reload to their loaded values, and the channel stays armed. In normal mode the repeat-select bit has no effect.
- R9: `irq_rpt` pulses at a repeat-mode block end only when the repeat-interrupt enable is 1. It never pulses in normal mode.
- R10: `err` stays set until reset or the next load. A load is accepted only while idle. It arms the channel if the count is non-zero and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load descriptor registers |
| cfg_ctrl | input | 8 | Control word |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Transfers per block |
| trig | input | 1 | Transfer trigger |
| ctrl_rd | output | 16 | Control register read value |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky error |
| irq_done | output | 1 | Normal-mode completion pulse |
| irq_rpt | output | 1 | Repeat block end pulse |
| chain_req | output | 1 | Request to start the next descriptor |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_we | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | ADDR_W | Bus address |
| bus_req_size | output | 2 | Width code of the access |
| bus_req_wdata | output | DATA_W | Write data |
| bus_rsp_valid | input | 1 | Read data valid |
| bus_rsp_rdata | input | DATA_W | Read data |

## Verification
The bench builds two copies with 32-bit addresses and data, a 16-bit count and 24 channels.

The main copy uses channel 3, where chain enable takes effect. That makes the chain request, the stalled-bus busy error and every width and mode combination reachable.

The second copy uses channel 23, the highest number. It brings the forced chain suppression into reach with the same control word.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_UPDATE
    } seq_state_e;

    // Bit order is decoded by the sequencer: MSB first.
    typedef struct packed {
        logic [1:0] width;
        logic       rpt_irq_en;
        logic       chain_en;
        logic       dst_inc;
        logic       src_inc;
        logic       rpt_src;
        logic       rpt_mode;
    } chan_ctrl_t;

    localparam logic [1:0] WIDTH_RESV = 2'b11;

    function automatic logic [2:0] width_bytes(input logic [1:0] w);
        logic [2:0] b;
        unique case (w)
            2'b00:   b = 3'd1;
            2'b01:   b = 3'd2;
            2'b10:   b = 3'd4;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
    import dma_seq_pkg::*;
(
    input  chan_ctrl_t ctrl,
    output logic       width_ok,
    output logic [1:0] side_adv,
    output logic [1:0] side_reload,
    output logic [2:0] step_bytes
);
    // side index 0 = source, 1 = destination
    always_comb begin
        width_ok       = (ctrl.width != WIDTH_RESV);
        step_bytes     = width_bytes(ctrl.width);
        side_reload[0] = ctrl.rpt_mode & ctrl.rpt_src;
        side_reload[1] = ctrl.rpt_mode & ~ctrl.rpt_src;
        // the repeat area always walks forward; its increment bit is unused
        side_adv[0]    = side_reload[0] | ctrl.src_inc;
        side_adv[1]    = side_reload[1] | ctrl.dst_inc;
    end
endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    input  logic              reload,
    input  logic [2:0]        step,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            base_q <= '0;
        end else if (load) begin
            cur    <= load_val;
            base_q <= load_val;
        end else if (reload) begin
            cur    <= base_q;
        end else if (advance) begin
            cur    <= cur + ADDR_W'(step);
        end
    end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             reload,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] init_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            init_q <= '0;
        end else if (load) begin
            cnt_q  <= load_val;
            init_q <= load_val;
        end else if (reload) begin
            cnt_q  <= init_q;
        end else if (dec) begin
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int NUM_CHAN = 24,
    parameter int CHAN_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_ctrl,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              trig,
    output logic [15:0]       ctrl_rd,
    output logic              busy,
    output logic              err,
    output logic              irq_done,
    output logic              irq_rpt,
    output logic              chain_req,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_we,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [1:0]        bus_req_size,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata
);
    localparam int LAST_CHAN = NUM_CHAN - 1;

    seq_state_e        state_q, state_d;
    chan_ctrl_t        ctrl_q;
    logic              armed_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;

    logic              width_ok;
    logic [1:0]        side_adv, side_reload;
    logic [2:0]        step_bytes;
    logic              chain_allow;
    logic              cnt_last;

    logic              is_idle, load_ok, start, trig_bad, in_update, block_end;
    logic [1:0][ADDR_W-1:0] addr_init, addr_cur;

    dma_ctrl_decode u_dec (
        .ctrl        (ctrl_q),
        .width_ok    (width_ok),
        .side_adv    (side_adv),
        .side_reload (side_reload),
        .step_bytes  (step_bytes)
    );

    // the top channel may never hand off to a following descriptor
    generate
        if (CHAN_ID == LAST_CHAN) begin : g_no_chain
            assign chain_allow = 1'b0;
        end else begin : g_chain
            assign chain_allow = ctrl_q.chain_en;
        end
    endgenerate

    assign is_idle   = (state_q == ST_IDLE);
    assign in_update = (state_q == ST_UPDATE);
    assign load_ok   = cfg_load & is_idle;
    assign start     = trig & is_idle & armed_q & width_ok;
    assign trig_bad  = trig & ((~is_idle) | (armed_q & ~width_ok));
    assign block_end = in_update & cnt_last;

    assign addr_init[0] = cfg_src;
    assign addr_init[1] = cfg_dst;

    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_addr_track #(.ADDR_W(ADDR_W)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_ok),
            .load_val (addr_init[g]),
            .advance  (in_update & side_adv[g]),
            .reload   (block_end & side_reload[g]),
            .step     (step_bytes),
            .cur      (addr_cur[g])
        );
    end

    dma_xfer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_count),
        .dec      (in_update),
        .reload   (block_end & ctrl_q.rpt_mode),
        .last     (cnt_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)         state_d = ST_RD_REQ;
            ST_RD_REQ:  if (bus_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (bus_rsp_valid) state_d = ST_WR_REQ;
            ST_WR_REQ:  if (bus_req_ready) state_d = ST_UPDATE;
            ST_UPDATE:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (load_ok) begin
                ctrl_q  <= chan_ctrl_t'(cfg_ctrl);
                armed_q <= (cfg_count != '0);
                err_q   <= 1'b0;
            end else begin
                if (trig_bad) err_q <= 1'b1;
                if (block_end & ~ctrl_q.rpt_mode) armed_q <= 1'b0;
            end
            if ((state_q == ST_RD_WAIT) && bus_rsp_valid) data_q <= bus_rsp_rdata;
        end
    end

    // outputs
    always_comb begin
        bus_req_valid = 1'b0;
        bus_req_we    = 1'b0;
        bus_req_addr  = addr_cur[0];
        unique case (state_q)
            ST_RD_REQ: begin
                bus_req_valid = 1'b1;
            end
            ST_WR_REQ: begin
                bus_req_valid = 1'b1;
                bus_req_we    = 1'b1;
                bus_req_addr  = addr_cur[1];
            end
            default: ;
        endcase
        bus_req_size  = ctrl_q.width;
        bus_req_wdata = data_q;
        busy          = ~is_idle;
        err           = err_q;
        ctrl_rd       = {8'h00, ctrl_q};
        irq_done      = block_end & ~ctrl_q.rpt_mode & ~chain_allow;
        chain_req     = block_end & ~ctrl_q.rpt_mode &  chain_allow;
        irq_rpt       = block_end &  ctrl_q.rpt_mode &  ctrl_q.rpt_irq_en;
    end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [15:0]       ctrl_rd,
    input logic              busy,
    input logic              err,
    input logic              irq_done,
    input logic              irq_rpt,
    input logic              chain_req,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic              bus_req_we,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic [1:0]        bus_req_size
);
    a_r2_no_resv_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_size != 2'b11));

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_we)));

    a_r6_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done || chain_req) |=> !busy);

    a_r7_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_done, chain_req, irq_rpt}));

    a_r9_rpt_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rpt |-> (ctrl_rd[0] && ctrl_rd[5]));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cfg_load) |=> err);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .ctrl_rd       (ctrl_rd),
    .busy          (busy),
    .err           (err),
    .irq_done      (irq_done),
    .irq_rpt       (irq_rpt),
    .chain_req     (chain_req),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_we    (bus_req_we),
    .bus_req_addr  (bus_req_addr),
    .bus_req_size  (bus_req_size)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_load = 1'b0;
    logic [7:0]    cfg_ctrl = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          trig = 1'b0, trig_l = 1'b0;
    logic          bus_ready = 1'b1;

    logic [15:0]   ctrl_rd, ctrl_rd_l;
    logic          busy, err, irq_done, irq_rpt, chain_req;
    logic          busy_l, err_l, irq_done_l, irq_rpt_l, chain_req_l;
    logic          rq_v, rq_we, rq_v_l, rq_we_l;
    logic [AW-1:0] rq_a, rq_a_l;
    logic [1:0]    rq_s, rq_s_l;
    logic [DW-1:0] rq_d, rq_d_l;
    logic          rsp_v = 1'b0, rsp_v_l = 1'b0;
    logic [DW-1:0] rsp_d = '0, rsp_d_l = '0;

    dma_chan_seq #(.CHAN_ID(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count), .trig(trig),
        .ctrl_rd(ctrl_rd), .busy(busy), .err(err), .irq_done(irq_done),
        .irq_rpt(irq_rpt), .chain_req(chain_req), .bus_req_valid(rq_v),
        .bus_req_ready(bus_ready), .bus_req_we(rq_we), .bus_req_addr(rq_a),
        .bus_req_size(rq_s), .bus_req_wdata(rq_d), .bus_rsp_valid(rsp_v),
        .bus_rsp_rdata(rsp_d));

    dma_chan_seq #(.CHAN_ID(23)) u_dut_last (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count), .trig(trig_l),
        .ctrl_rd(ctrl_rd_l), .busy(busy_l), .err(err_l), .irq_done(irq_done_l),
        .irq_rpt(irq_rpt_l), .chain_req(chain_req_l), .bus_req_valid(rq_v_l),
        .bus_req_ready(1'b1), .bus_req_we(rq_we_l), .bus_req_addr(rq_a_l),
        .bus_req_size(rq_s_l), .bus_req_wdata(rq_d_l), .bus_rsp_valid(rsp_v_l),
        .bus_rsp_rdata(rsp_d_l));

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    // memory model and logs
    logic [AW-1:0] rd_a [64];
    logic [AW-1:0] wr_a [64];
    logic [DW-1:0] wr_d [64];
    logic [1:0]    wr_s [64];
    int rd_n = 0, wr_n = 0;
    int n_done = 0, n_rpt = 0, n_chain = 0, n_done_l = 0, n_chain_l = 0;

    always @(posedge clk) begin
        rsp_v   <= rq_v && bus_ready && !rq_we;
        rsp_d   <= mem_val(rq_a);
        rsp_v_l <= rq_v_l && !rq_we_l;
        rsp_d_l <= mem_val(rq_a_l);
        if (rq_v && bus_ready) begin
            if (rq_we) begin
                wr_a[wr_n[5:0]] <= rq_a; wr_d[wr_n[5:0]] <= rq_d; wr_s[wr_n[5:0]] <= rq_s;
                wr_n <= wr_n + 1;
            end else begin
                rd_a[rd_n[5:0]] <= rq_a;
                rd_n <= rd_n + 1;
            end
        end
        if (irq_done)    n_done    <= n_done + 1;
        if (irq_rpt)     n_rpt     <= n_rpt + 1;
        if (chain_req)   n_chain   <= n_chain + 1;
        if (irq_done_l)  n_done_l  <= n_done_l + 1;
        if (chain_req_l) n_chain_l <= n_chain_l + 1;
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] c, input logic [AW-1:0] s,
                        input logic [AW-1:0] d, input logic [CW-1:0] n);
        @(negedge clk);
        cfg_ctrl = c; cfg_src = s; cfg_dst = d; cfg_count = n; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        rd_n = 0; wr_n = 0;
    endtask

    task automatic fire();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic check_xfer(input string req, input int i, input logic [AW-1:0] sa,
                              input logic [AW-1:0] da, input logic [1:0] sz);
        check(req, $sformatf("read %0d addr", i), rd_a[i], sa);
        check(req, $sformatf("write %0d addr", i), wr_a[i], da);
        check(req, $sformatf("write %0d data", i), wr_d[i], mem_val(sa));
        check(req, $sformatf("write %0d size", i), wr_s[i], sz);
    endtask

    task automatic t_reset();
        check("R1", "ctrl_rd after reset", ctrl_rd, 0);
        check("R1", "busy after reset", busy, 0);
        check("R1", "err after reset", err, 0);
        check("R1", "req_valid after reset", rq_v, 0);
    endtask

    task automatic t_normal_16();
        int d0;
        load(8'h4C, 32'h100, 32'h200, 3);
        check("R1", "ctrl_rd readback", ctrl_rd, 16'h004C);
        d0 = n_done;
        fire(); fire();
        check("R6", "no done before last", n_done - d0, 0);
        fire();
        check("R6", "done after third", n_done - d0, 1);
        for (int i = 0; i < 3; i++)
            check_xfer("R5", i, 32'h100 + 2*i, 32'h200 + 2*i, 2'b01);
        fire();
        check("R6", "reads after stop", rd_n, 3);
        check("R6", "no error on disarmed trigger", err, 0);
        check("R4", "write count", wr_n, 3);
    endtask

    task automatic t_widths();
        load(8'h88, 32'h40, 32'h80, 2);
        fire(); fire();
        check_xfer("R5", 0, 32'h40, 32'h80, 2'b10);
        check_xfer("R5", 1, 32'h40, 32'h84, 2'b10);
        load(8'h0C, 32'h10, 32'h20, 2);
        fire(); fire();
        check_xfer("R5", 1, 32'h11, 32'h21, 2'b00);
    endtask

    task automatic t_reserved();
        load(8'hC0, 32'h10, 32'h20, 1);
        fire();
        check("R2", "reads on reserved width", rd_n, 0);
        check("R2", "writes on reserved width", wr_n, 0);
        check("R2", "err set", err, 1);
        repeat (5) @(negedge clk);
        check("R10", "err held", err, 1);
        load(8'h0C, 32'h10, 32'h20, 1);
        check("R10", "err cleared by load", err, 0);
    endtask

    task automatic t_busy();
        load(8'h0C, 32'h30, 32'h60, 4);
        @(negedge clk); bus_ready = 1'b0; trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (2) @(negedge clk);
        check("R3", "busy while stalled", busy, 1);
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check("R3", "err on busy trigger", err, 1);
        bus_ready = 1'b1;
        repeat (8) @(negedge clk);
        check("R3", "single read", rd_n, 1);
        check("R3", "single write", wr_n, 1);
        check_xfer("R4", 0, 32'h30, 32'h60, 2'b00);
    endtask

    task automatic t_chain();
        int d0, c0, dl0, cl0;
        d0 = n_done; c0 = n_chain; dl0 = n_done_l; cl0 = n_chain_l;
        load(8'h1C, 32'h90, 32'hA0, 1);
        fire();
        check("R7", "chain requested", n_chain - c0, 1);
        check("R7", "no done when chaining", n_done - d0, 0);
        @(negedge clk); trig_l = 1'b1;
        @(negedge clk); trig_l = 1'b0;
        repeat (7) @(negedge clk);
        check("R7", "top channel done", n_done_l - dl0, 1);
        check("R7", "top channel no chain", n_chain_l - cl0, 0);
    endtask

    task automatic t_repeat_dst();
        int r0, d0;
        r0 = n_rpt; d0 = n_done;
        load(8'h25, 32'h300, 32'h400, 2);
        for (int i = 0; i < 5; i++) fire();
        for (int i = 0; i < 5; i++)
            check_xfer("R8", i, 32'h300 + i, 32'h400 + (i % 2), 2'b00);
        check("R9", "repeat irq count", n_rpt - r0, 2);
        check("R8", "no done in repeat", n_done - d0, 0);
    endtask

    task automatic t_repeat_src();
        int r0;
        r0 = n_rpt;
        load(8'h03, 32'h500, 32'h600, 2);
        for (int i = 0; i < 3; i++) fire();
        for (int i = 0; i < 3; i++)
            check_xfer("R8", i, 32'h500 + (i % 2), 32'h600, 2'b00);
        check("R9", "repeat irq disabled", n_rpt - r0, 0);
    endtask

    task automatic t_normal_sel();
        int r0, d0;
        r0 = n_rpt; d0 = n_done;
        load(8'h26, 32'h700, 32'h800, 2);
        fire(); fire();
        check_xfer("R8", 0, 32'h700, 32'h800, 2'b00);
        check_xfer("R8", 1, 32'h701, 32'h800, 2'b00);
        check("R9", "no repeat irq in normal", n_rpt - r0, 0);
        check("R6", "done in normal", n_done - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normal_16();
        t_widths();
        t_reserved();
        t_busy();
        t_chain();
        t_repeat_dst();
        t_repeat_src();
        t_normal_sel();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule